// File: doc/BRIEF.md
# Hierarchical State Controller with History

This block is a clocked controller built from two levels of states. The outer level has two states: `TOP_IDLE` and the superstate `TOP_SUPER`. Inside `TOP_SUPER` exactly one of five basic substates, `SUB_A` to `SUB_E`, is active. They advance in a ring on a step event. `SUB_C` is a waiting substate. It leaves only when an acknowledge event arrives, or when a timeout edge fires after `TIMEOUT_CYC` cycles without one.

The superstate can be entered in two ways:
- A default entry (`ev_enter`) always lands in `SUB_A`.
- A history entry (`ev_resume`) resumes the substate that was active at the last exit. Before any exit, it lands in `SUB_A`.

Named transitions:
- `T_ENTER`: IDLE→A
- `T_RESUME`: IDLE→history
- `T_LEAVE`: any→IDLE
- `T_AB`: A→B on step
- `T_BC`: B→C on step, guarded by the level `cond_arm`
- `T_CD`: C→D on ack
- `T_CE`: C→E, the timeout edge
- `T_DE`: D→E on step
- `T_EA`: E→A on step. Its reaction swaps the two variables `var_p` and `var_q`.

All next values are computed from current values and committed together at one clock edge. Every value written in a step is seen by all parts of the block in the next step. A generated event, such as the timeout flag, is high for exactly one cycle.

Top module: `hsc_ctrl`

## Requirements
- R1: After reset:
  - the controller is in IDLE, with `in_super`=0 and `sub_active`=0;
  - `hist_valid`=0 and `hist_sub`=0;
  - `timeout_flag`=0;
  - `var_p`=`P_INIT` and `var_q`=`Q_INIT`.
- R2: While `in_super` is 1, `sub_active` has exactly one bit set (bit 0=A, 1=B, 2=C, 3=D, 4=E). While in IDLE, `sub_active` is 0.
- R3: `ev_enter` in IDLE makes `SUB_A` active in the next cycle.
- R4: In A a step moves to B. In D a step moves to E. In B a step moves to C only while `cond_arm`=1; otherwise B holds.
- R5: In C a step has no effect, and `ev_ack` moves to D.
- R6: If C stays active for `TIMEOUT_CYC` cycles without `ev_ack`, the controller moves to E and `timeout_flag` is 1 for exactly that next cycle. An ack in the last cycle wins over the timeout.
- R7: The timeout window restarts in full on every entry into C, including an entry through history.
- R8: `ev_leave` in the superstate returns to IDLE. It stores the active substate in `hist_sub` (same one-hot coding) and sets `hist_valid`.
- R9: `ev_resume` in IDLE re-activates `hist_sub` when `hist_valid`=1, and A otherwise. `ev_resume` takes priority over a simultaneous `ev_enter`.
- R10: `ev_leave` wins over a step in the same cycle. The stored history is the substate active before that step.
- R11: A step in E moves to A and exchanges `var_p` and `var_q` in one commit.
- R12: These events leave state and history unchanged:
  - step, ack and leave while in IDLE;
  - enter and resume while in the superstate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_enter | input | 1 | Default-entry event pulse |
| ev_resume | input | 1 | History-entry event pulse |
| ev_leave | input | 1 | Leave-superstate event pulse |
| ev_step | input | 1 | Step event pulse |
| ev_ack | input | 1 | Awaited event pulse for substate C |
| cond_arm | input | 1 | Level condition guarding B→C |
| sub_active | output | 5 | One-hot active substate, 0 in IDLE |
| in_super | output | 1 | Superstate active |
| hist_sub | output | 5 | One-hot stored history substate |
| hist_valid | output | 1 | History has been captured |
| timeout_flag | output | 1 | One-cycle timeout event |
| var_p | output | VAR_W | Variable p |
| var_q | output | VAR_W | Variable q |

## Verification
The bench builds the block with `TIMEOUT_CYC`=6, `VAR_W`=8, `P_INIT`=8'h3C and `Q_INIT`=8'hA5. The short window makes two sweeps affordable:
- every ack arrival cycle, from the first cycle in C through the last, plus no ack at all;
- exits from and history re-entries to each of the five substates.

Distinct variable values make a missed or one-sided swap visible.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    localparam int NUM_SUB = 5;

    typedef enum logic [0:0] {
        TOP_IDLE  = 1'b0,
        TOP_SUPER = 1'b1
    } top_e;

    typedef enum logic [2:0] {
        SUB_A = 3'd0,
        SUB_B = 3'd1,
        SUB_C = 3'd2,
        SUB_D = 3'd3,
        SUB_E = 3'd4
    } sub_e;

    localparam sub_e SUB_DEFAULT = SUB_A;
    localparam sub_e SUB_WAIT    = SUB_C;

    function automatic logic [NUM_SUB-1:0] sub_onehot(input sub_e s);
        logic [NUM_SUB-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/hsc_timer.sv
module hsc_timer #(
    parameter int LIMIT = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stay,
    input  logic in_wait,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (load)
            cnt_d = CNT_W'(LIMIT);
        else if (stay)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expire = in_wait && (cnt_q == CNT_W'(1));

    // R7: the window is never exhausted while the waiting substate is active
    a_r7_live_window: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait |-> (cnt_q != '0));
endmodule

// File: rtl/hsc_history.sv
module hsc_history
    import hsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  sub_e cur_sub,
    output sub_e hist_q,
    output logic valid_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= SUB_DEFAULT;
            valid_q <= 1'b0;
        end else if (capture) begin
            hist_q  <= cur_sub;
            valid_q <= 1'b1;
        end
    end

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (valid_q && hist_q == $past(cur_sub)));

    a_r12_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(hist_q) && $stable(valid_q)));
endmodule

// File: rtl/hsc_vars.sv
module hsc_vars #(
    parameter int VAR_W = 8,
    parameter logic [VAR_W-1:0] P_INIT = '0,
    parameter logic [VAR_W-1:0] Q_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_swap,
    output logic [VAR_W-1:0] p_q,
    output logic [VAR_W-1:0] q_q
);
    logic [VAR_W-1:0] p_d;
    logic [VAR_W-1:0] q_d;

    // both right-hand sides come from current values; commit together
    always_comb begin
        p_d = p_q;
        q_d = q_q;
        if (do_swap) begin
            p_d = q_q;
            q_d = p_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= P_INIT;
            q_q <= Q_INIT;
        end else begin
            p_q <= p_d;
            q_q <= q_d;
        end
    end

    a_r11_swap: assert property (@(posedge clk) disable iff (!rst_n)
        do_swap |=> (p_q == $past(q_q) && q_q == $past(p_q)));
endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
    import hsc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000000,
    parameter int VAR_W = 8,
    parameter logic [VAR_W-1:0] P_INIT = 8'h00,
    parameter logic [VAR_W-1:0] Q_INIT = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_enter,
    input  logic                 ev_resume,
    input  logic                 ev_leave,
    input  logic                 ev_step,
    input  logic                 ev_ack,
    input  logic                 cond_arm,
    output logic [NUM_SUB-1:0]   sub_active,
    output logic                 in_super,
    output logic [NUM_SUB-1:0]   hist_sub,
    output logic                 hist_valid,
    output logic                 timeout_flag,
    output logic [VAR_W-1:0]     var_p,
    output logic [VAR_W-1:0]     var_q
);
    top_e top_q, top_d;
    sub_e sub_q, sub_d;
    logic tmo_q, tmo_d;
    logic capture, do_swap, expire;
    logic tmr_load, tmr_stay, in_wait;
    sub_e hist_st;
    logic hist_ok;

    assign in_wait  = (top_q == TOP_SUPER) && (sub_q == SUB_WAIT);
    assign tmr_stay = in_wait && (top_d == TOP_SUPER) && (sub_d == SUB_WAIT);
    assign tmr_load = (top_d == TOP_SUPER) && (sub_d == SUB_WAIT) && !in_wait;

    // next-state logic: every transition computed from current values
    always_comb begin
        top_d   = top_q;
        sub_d   = sub_q;
        tmo_d   = 1'b0;
        capture = 1'b0;
        do_swap = 1'b0;
        unique case (top_q)
            TOP_IDLE: begin
                if (ev_resume) begin                      // T_RESUME
                    top_d = TOP_SUPER;
                    sub_d = hist_ok ? hist_st : SUB_DEFAULT;
                end else if (ev_enter) begin              // T_ENTER
                    top_d = TOP_SUPER;
                    sub_d = SUB_DEFAULT;
                end
            end
            TOP_SUPER: begin
                if (ev_leave) begin                       // T_LEAVE
                    top_d   = TOP_IDLE;
                    capture = 1'b1;
                end else begin
                    unique case (sub_q)
                        SUB_A: if (ev_step) sub_d = SUB_B;             // T_AB
                        SUB_B: if (ev_step && cond_arm) sub_d = SUB_C; // T_BC
                        SUB_C: begin
                            if (ev_ack)
                                sub_d = SUB_D;                         // T_CD
                            else if (expire) begin
                                sub_d = SUB_E;                         // T_CE
                                tmo_d = 1'b1;
                            end
                        end
                        SUB_D: if (ev_step) sub_d = SUB_E;             // T_DE
                        SUB_E: if (ev_step) begin                      // T_EA
                            sub_d   = SUB_A;
                            do_swap = 1'b1;
                        end
                        default: sub_d = SUB_DEFAULT;
                    endcase
                end
            end
            default: top_d = TOP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= TOP_IDLE;
            sub_q <= SUB_DEFAULT;
            tmo_q <= 1'b0;
        end else begin
            top_q <= top_d;
            sub_q <= sub_d;
            tmo_q <= tmo_d;
        end
    end

    // outputs
    always_comb begin
        in_super     = (top_q == TOP_SUPER);
        sub_active   = in_super ? sub_onehot(sub_q) : '0;
        hist_sub     = hist_ok ? sub_onehot(hist_st) : '0;
        hist_valid   = hist_ok;
        timeout_flag = tmo_q;
    end

    hsc_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .stay    (tmr_stay),
        .in_wait (in_wait),
        .expire  (expire)
    );

    hsc_history u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .cur_sub (sub_q),
        .hist_q  (hist_st),
        .valid_q (hist_ok)
    );

    hsc_vars #(.VAR_W(VAR_W), .P_INIT(P_INIT), .Q_INIT(Q_INIT)) u_vars (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_swap (do_swap),
        .p_q     (var_p),
        .q_q     (var_q)
    );

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        in_super |-> ($countones(sub_active) == 1));

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !in_super |-> (sub_active == '0));

    a_r8_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (in_super && ev_leave) |=> (!in_super && hist_sub == $past(sub_active)));

    a_r6_timeout_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && expire && !ev_leave && !ev_ack) |=> (timeout_flag && sub_active[SUB_E]));

    a_r6_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> !timeout_flag);

    a_r5_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !ev_ack && !ev_leave && !expire) |=> sub_active[SUB_C]);
endmodule

// File: tb/hsc_ctrl_bench.sv
module hsc_ctrl_bench;
    localparam int T = 6;
    localparam logic [7:0] PI = 8'h3C;
    localparam logic [7:0] QI = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_enter = 0, ev_resume = 0, ev_leave = 0, ev_step = 0, ev_ack = 0;
    logic cond_arm = 1'b1;
    logic [4:0] sub_active, hist_sub;
    logic in_super, hist_valid, timeout_flag;
    logic [7:0] var_p, var_q;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hsc_ctrl #(.TIMEOUT_CYC(T), .VAR_W(8), .P_INIT(PI), .Q_INIT(QI)) u_hsc_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_enter(ev_enter), .ev_resume(ev_resume),
        .ev_leave(ev_leave), .ev_step(ev_step), .ev_ack(ev_ack), .cond_arm(cond_arm),
        .sub_active(sub_active), .in_super(in_super), .hist_sub(hist_sub),
        .hist_valid(hist_valid), .timeout_flag(timeout_flag),
        .var_p(var_p), .var_q(var_q)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive events for one cycle from the falling edge; outputs checked at next falling edge
    task automatic tick(input logic en, input logic rs, input logic lv,
                        input logic st, input logic ak);
        ev_enter = en; ev_resume = rs; ev_leave = lv; ev_step = st; ev_ack = ak;
        @(negedge clk);
        ev_enter = 0; ev_resume = 0; ev_leave = 0; ev_step = 0; ev_ack = 0;
    endtask

    function automatic logic [4:0] oh(input int k);
        return 5'(1) << k;
    endfunction

    // from A, walk to substate k (C is left by ack)
    task automatic walk(input int k);
        for (int i = 0; i < k; i++) begin
            if (i == 2) tick(0, 0, 0, 0, 1);
            else        tick(0, 0, 0, 1, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 in_super", 32'(in_super), 0);
        chk("R1 sub_active", 32'(sub_active), 0);
        chk("R1 hist_valid", 32'(hist_valid), 0);
        chk("R1 hist_sub", 32'(hist_sub), 0);
        chk("R1 timeout_flag", 32'(timeout_flag), 0);
        chk("R1 var_p", 32'(var_p), 32'(PI));
        chk("R1 var_q", 32'(var_q), 32'(QI));

        // R9: resume before any exit acts as default entry
        tick(0, 1, 0, 0, 0);
        chk("R9 resume no history", 32'(sub_active), 32'(oh(0)));
        tick(0, 0, 1, 0, 0);

        // R12: events in IDLE
        tick(0, 0, 0, 1, 0); tick(0, 0, 0, 0, 1); tick(0, 0, 1, 0, 0);
        chk("R12 idle events state", 32'({in_super, sub_active}), 0);
        chk("R12 idle events hist", 32'(hist_sub), 32'(oh(0)));

        // R3, R4, R2: default entry and sequencing, B guard
        tick(1, 0, 0, 0, 0);
        chk("R3 enter to A", 32'(sub_active), 32'(oh(0)));
        chk("R2 in_super", 32'(in_super), 1);
        tick(0, 0, 0, 1, 0);
        chk("R4 A to B", 32'(sub_active), 32'(oh(1)));
        cond_arm = 1'b0;
        tick(0, 0, 0, 1, 0);
        chk("R4 B holds when guard low", 32'(sub_active), 32'(oh(1)));
        cond_arm = 1'b1;
        // R12: enter/resume inside superstate
        tick(1, 1, 0, 0, 0);
        chk("R12 enter in super", 32'(sub_active), 32'(oh(1)));
        tick(0, 0, 0, 1, 0);
        chk("R4 B to C", 32'(sub_active), 32'(oh(2)));
        tick(0, 0, 0, 1, 0);
        chk("R5 step ignored in C", 32'(sub_active), 32'(oh(2)));
        tick(0, 0, 0, 0, 1);
        chk("R5 ack to D", 32'(sub_active), 32'(oh(3)));
        tick(0, 0, 0, 1, 0);
        chk("R4 D to E", 32'(sub_active), 32'(oh(4)));
        // R11
        tick(0, 0, 0, 1, 0);
        chk("R11 E to A", 32'(sub_active), 32'(oh(0)));
        chk("R11 p swapped", 32'(var_p), 32'(QI));
        chk("R11 q swapped", 32'(var_q), 32'(PI));
        walk(4);
        tick(0, 0, 0, 1, 0);
        chk("R11 second swap p", 32'(var_p), 32'(PI));
        chk("R11 second swap q", 32'(var_q), 32'(QI));
        tick(0, 0, 1, 0, 0);

        // R8, R9: history sweep over all substates
        for (int k = 0; k < 5; k++) begin
            tick(1, 0, 0, 0, 0);
            walk(k);
            tick(0, 0, 1, 0, 0);
            chk("R8 idle after leave", 32'(in_super), 0);
            chk("R8 hist captured", 32'(hist_sub), 32'(oh(k)));
            chk("R8 hist valid", 32'(hist_valid), 1);
            tick(1, 1, 0, 0, 0);
            chk("R9 resume restores", 32'(sub_active), 32'(oh(k)));
            tick(0, 0, 1, 0, 0);
            tick(1, 0, 0, 0, 0);
            chk("R3 default ignores history", 32'(sub_active), 32'(oh(0)));
            tick(0, 0, 1, 0, 0);
        end

        // R10: leave beats step
        tick(1, 0, 0, 0, 0);
        tick(0, 0, 0, 1, 0);
        tick(0, 0, 1, 1, 0);
        chk("R10 leave wins", 32'(in_super), 0);
        chk("R10 hist pre-step", 32'(hist_sub), 32'(oh(1)));

        // R6: ack arrival sweep (j = T+1 means no ack)
        for (int j = 1; j <= T + 1; j++) begin
            tick(1, 0, 0, 0, 0);
            walk(2);
            for (int c = 1; c <= T; c++) begin
                if (c == j) begin
                    tick(0, 0, 0, 0, 1);
                    chk("R6 ack wins", 32'(sub_active), 32'(oh(3)));
                    chk("R6 no flag on ack", 32'(timeout_flag), 0);
                    break;
                end
                tick(0, 0, 0, 0, 0);
                if (c == T) begin
                    chk("R6 timeout to E", 32'(sub_active), 32'(oh(4)));
                    chk("R6 flag raised", 32'(timeout_flag), 1);
                end else begin
                    chk("R6 still waiting", 32'(sub_active), 32'(oh(2)));
                    chk("R6 flag low", 32'(timeout_flag), 0);
                end
            end
            tick(0, 0, 0, 0, 0);
            chk("R6 flag one cycle", 32'(timeout_flag), 0);
            tick(0, 0, 1, 0, 0);
        end

        // R7: window restarts in full after history re-entry
        tick(1, 0, 0, 0, 0);
        walk(2);
        tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
        tick(0, 0, 1, 0, 0);
        tick(0, 1, 0, 0, 0);
        chk("R7 resumed in C", 32'(sub_active), 32'(oh(2)));
        for (int c = 1; c < T; c++) tick(0, 0, 0, 0, 0);
        chk("R7 full window still C", 32'(sub_active), 32'(oh(2)));
        tick(0, 0, 0, 0, 0);
        chk("R7 expires after full window", 32'(sub_active), 32'(oh(4)));
        chk("R7 flag", 32'(timeout_flag), 1);

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule